// File: doc/BRIEF.md
# PTP End-to-End Delay and Offset Calculator

This block turns the four event timestamps of one end-to-end delay exchange into the mean path delay and the clock offset of the slave. The four events are the master sending Sync (t1), the slave receiving that Sync (t2), the slave sending Delay_Req (t3) and the master receiving that Delay_Req (t4). Each timestamp arrives as seconds and nanoseconds with its own valid strobe, in any order and over any number of cycles. When the set is complete, the block produces signed 64-bit nanosecond results with a one-cycle valid pulse.

Before the arithmetic runs, each timestamp is moved to its wire event. An egress capture gets the transmit latency added. An ingress capture gets the receive latency subtracted. Accumulated correction terms for each direction (residence time and calibrated link terms) are removed from the raw differences. The method assumes equal forward and reverse delays, so a static asymmetry value is subtracted from the offset to compensate for known imbalance. A negative mean delay can only come from bad inputs. It is reported on an error pulse and no result is issued.

Top module: `ptp_e2e_calc`

## Requirements
- R1: A timestamp normalises to seconds*1e9 + nanoseconds. The egress events t1 and t3 then have tx_lat_i added, and the ingress events t2 and t4 have rx_lat_i subtracted.
- R2: corr_sync_i is sampled only on the t2 strobe, and corr_dreq_i is sampled only on the t4 strobe. Changes at other times have no effect on the result.
- R3: Let fwd = t2 - t1 - corr_sync and rev = t4 - t3 - corr_dreq. Then delay_o = floor((fwd + rev) / 2), rounding toward minus infinity.
- R4: offset_o = fwd - delay_o - asym_i, where asym_i is sign-extended.
- R5: A result is produced once all four strobes have been seen since the last completion. The strobes may come in any order and in any cycles, including all four in one cycle. If the last strobe is sampled at rising edge n, res_vld_o is high after edge n+2 and low after edge n+1.
- R6: A repeated strobe for a timestamp before completion replaces the value held for that timestamp.
- R7: If the mean delay is negative, res_err_o pulses instead of res_vld_o, and delay_o and offset_o keep their previous values.
- R8: While rst_ni is low, the outputs read zero and all partly collected timestamps are discarded.
- R9: res_vld_o and res_err_o are single-cycle pulses that are never high together. delay_o and offset_o change only with a res_vld_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| t1_vld_i | input | 1 | Sync transmit timestamp strobe |
| t1_sec_i | input | SEC_W | Sync transmit seconds |
| t1_ns_i | input | NS_W | Sync transmit nanoseconds |
| t2_vld_i | input | 1 | Sync receive timestamp strobe |
| t2_sec_i | input | SEC_W | Sync receive seconds |
| t2_ns_i | input | NS_W | Sync receive nanoseconds |
| t3_vld_i | input | 1 | Delay_Req transmit timestamp strobe |
| t3_sec_i | input | SEC_W | Delay_Req transmit seconds |
| t3_ns_i | input | NS_W | Delay_Req transmit nanoseconds |
| t4_vld_i | input | 1 | Delay_Req receive timestamp strobe |
| t4_sec_i | input | SEC_W | Delay_Req receive seconds |
| t4_ns_i | input | NS_W | Delay_Req receive nanoseconds |
| corr_sync_i | input | CORR_W | Signed ns correction for the master-to-slave direction |
| corr_dreq_i | input | CORR_W | Signed ns correction for the slave-to-master direction |
| asym_i | input | ASYM_W | Signed ns static path asymmetry |
| tx_lat_i | input | LAT_W | Egress capture-to-wire latency in ns |
| rx_lat_i | input | LAT_W | Ingress wire-to-capture latency in ns |
| res_vld_o | output | 1 | Result valid pulse |
| res_err_o | output | 1 | Negative mean delay pulse |
| delay_o | output | 64 | Signed mean path delay in ns |
| offset_o | output | 64 | Signed slave clock offset in ns |

## Verification
Every result is due on the second rising edge after the edge that samples the last of the four strobes. This holds for a good result on res_vld_o and for a rejected one on res_err_o. Each strobe is driven on a falling edge and dropped on the next one. After that, each check samples on a falling edge: the output pulse must be low one cycle after the sampling edge, present two cycles after it, and gone three cycles after it. Cases that must produce no output are watched over several falling edges after their stimulus.

// File: rtl/ptp_e2e_pkg.sv
package ptp_e2e_pkg;
  localparam int TIME_W = 64;
  localparam int NUM_TS = 4;
  localparam logic [TIME_W-1:0] NS_PER_SEC = 64'd1_000_000_000;

  typedef logic signed [TIME_W-1:0] ns_t;

  // index order is fixed: the math stage decodes it
  typedef enum int {
    TS_SYNC_TX = 0,
    TS_SYNC_RX = 1,
    TS_DREQ_TX = 2,
    TS_DREQ_RX = 3
  } ts_idx_e;
endpackage

// File: rtl/ts_norm.sv
module ts_norm
  import ptp_e2e_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 32,
  parameter int LAT_W  = 32,
  parameter bit EGRESS = 1'b0
) (
  input  logic [SEC_W-1:0] sec_i,
  input  logic [NS_W-1:0]  ns_i,
  input  logic [LAT_W-1:0] lat_i,
  output ns_t              ts_o
);
  logic [TIME_W-1:0] base;
  logic [TIME_W-1:0] lat_x;

  always_comb begin
    base  = TIME_W'(sec_i) * NS_PER_SEC + TIME_W'(ns_i);
    lat_x = TIME_W'(lat_i);
  end

  // egress capture precedes the wire, ingress capture follows it
  generate
    if (EGRESS) begin : g_tx
      assign ts_o = ns_t'(base + lat_x);
    end else begin : g_rx
      assign ts_o = ns_t'(base - lat_x);
    end
  endgenerate
endmodule

// File: rtl/ts_collect.sv
module ts_collect
  import ptp_e2e_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_TS-1:0]        vld_i,
  input  ns_t  [NUM_TS-1:0]        ts_i,
  input  ns_t                      corr_sync_i,
  input  ns_t                      corr_dreq_i,
  output ns_t  [NUM_TS-1:0]        ts_o,
  output ns_t                      corr_sync_o,
  output ns_t                      corr_dreq_o,
  output logic                     go_o
);
  logic [NUM_TS-1:0] have_q, have_nx;
  logic              all_in;
  logic              go_q;
  ns_t  [NUM_TS-1:0] ts_q;
  ns_t               cs_q, cd_q;

  assign have_nx = have_q | vld_i;
  assign all_in  = &have_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= '0;
      go_q   <= 1'b0;
    end else begin
      have_q <= all_in ? '0 : have_nx;
      go_q   <= all_in;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q <= '0;
      cs_q <= '0;
      cd_q <= '0;
    end else begin
      for (int i = 0; i < NUM_TS; i++) begin
        if (vld_i[i]) ts_q[i] <= ts_i[i];
      end
      if (vld_i[TS_SYNC_RX]) cs_q <= corr_sync_i;
      if (vld_i[TS_DREQ_RX]) cd_q <= corr_dreq_i;
    end
  end

  assign ts_o        = ts_q;
  assign corr_sync_o = cs_q;
  assign corr_dreq_o = cd_q;
  assign go_o        = go_q;
endmodule

// File: rtl/e2e_math.sv
module e2e_math
  import ptp_e2e_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  ns_t [NUM_TS-1:0]  ts_i,
  input  ns_t               corr_sync_i,
  input  ns_t               corr_dreq_i,
  input  ns_t               asym_i,
  output logic              vld_o,
  output logic              err_o,
  output ns_t               delay_o,
  output ns_t               offset_o
);
  ns_t  fwd_q, rev_q;
  logic s1_q;
  ns_t  sum, mean, off;
  logic neg;
  logic vld_q, err_q;
  ns_t  delay_q, offset_q;

  // stage 1: corrected one-way differences
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_q <= '0;
      rev_q <= '0;
      s1_q  <= 1'b0;
    end else begin
      s1_q <= go_i;
      if (go_i) begin
        fwd_q <= ts_i[TS_SYNC_RX] - ts_i[TS_SYNC_TX] - corr_sync_i;
        rev_q <= ts_i[TS_DREQ_RX] - ts_i[TS_DREQ_TX] - corr_dreq_i;
      end
    end
  end

  // stage 2: mean delay (floor halving) and offset
  always_comb begin
    sum  = fwd_q + rev_q;
    mean = sum >>> 1;
    neg  = mean[TIME_W-1];
    off  = fwd_q - mean - asym_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q    <= 1'b0;
      err_q    <= 1'b0;
      delay_q  <= '0;
      offset_q <= '0;
    end else begin
      vld_q <= s1_q && !neg;
      err_q <= s1_q && neg;
      if (s1_q && !neg) begin
        delay_q  <= mean;
        offset_q <= off;
      end
    end
  end

  assign vld_o    = vld_q;
  assign err_o    = err_q;
  assign delay_o  = delay_q;
  assign offset_o = offset_q;
endmodule

// File: rtl/ptp_e2e_calc.sv
module ptp_e2e_calc
  import ptp_e2e_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 32,
  parameter int LAT_W  = 32,
  parameter int CORR_W = 64,
  parameter int ASYM_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     t1_vld_i,
  input  logic [SEC_W-1:0]         t1_sec_i,
  input  logic [NS_W-1:0]          t1_ns_i,
  input  logic                     t2_vld_i,
  input  logic [SEC_W-1:0]         t2_sec_i,
  input  logic [NS_W-1:0]          t2_ns_i,
  input  logic                     t3_vld_i,
  input  logic [SEC_W-1:0]         t3_sec_i,
  input  logic [NS_W-1:0]          t3_ns_i,
  input  logic                     t4_vld_i,
  input  logic [SEC_W-1:0]         t4_sec_i,
  input  logic [NS_W-1:0]          t4_ns_i,
  input  logic signed [CORR_W-1:0] corr_sync_i,
  input  logic signed [CORR_W-1:0] corr_dreq_i,
  input  logic signed [ASYM_W-1:0] asym_i,
  input  logic [LAT_W-1:0]         tx_lat_i,
  input  logic [LAT_W-1:0]         rx_lat_i,
  output logic                     res_vld_o,
  output logic                     res_err_o,
  output logic signed [TIME_W-1:0] delay_o,
  output logic signed [TIME_W-1:0] offset_o
);
  logic [NUM_TS-1:0]            vld_a;
  logic [NUM_TS-1:0][SEC_W-1:0] sec_a;
  logic [NUM_TS-1:0][NS_W-1:0]  ns_a;
  ns_t  [NUM_TS-1:0]            norm_ts;
  ns_t  [NUM_TS-1:0]            held_ts;
  ns_t                          cs_ext, cd_ext, asym_ext;
  ns_t                          cs_q, cd_q;
  logic                         go;

  assign vld_a    = {t4_vld_i, t3_vld_i, t2_vld_i, t1_vld_i};
  assign sec_a    = {t4_sec_i, t3_sec_i, t2_sec_i, t1_sec_i};
  assign ns_a     = {t4_ns_i, t3_ns_i, t2_ns_i, t1_ns_i};
  assign cs_ext   = ns_t'(corr_sync_i);
  assign cd_ext   = ns_t'(corr_dreq_i);
  assign asym_ext = ns_t'(asym_i);

  generate
    for (genvar g = 0; g < NUM_TS; g++) begin : g_norm
      localparam bit IS_TX = (g % 2) == 0;
      ts_norm #(
        .SEC_W (SEC_W),
        .NS_W  (NS_W),
        .LAT_W (LAT_W),
        .EGRESS(IS_TX)
      ) u_norm (
        .sec_i(sec_a[g]),
        .ns_i (ns_a[g]),
        .lat_i(IS_TX ? tx_lat_i : rx_lat_i),
        .ts_o (norm_ts[g])
      );
    end
  endgenerate

  ts_collect u_collect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vld_i      (vld_a),
    .ts_i       (norm_ts),
    .corr_sync_i(cs_ext),
    .corr_dreq_i(cd_ext),
    .ts_o       (held_ts),
    .corr_sync_o(cs_q),
    .corr_dreq_o(cd_q),
    .go_o       (go)
  );

  e2e_math u_math (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go),
    .ts_i       (held_ts),
    .corr_sync_i(cs_q),
    .corr_dreq_i(cd_q),
    .asym_i     (asym_ext),
    .vld_o      (res_vld_o),
    .err_o      (res_err_o),
    .delay_o    (delay_o),
    .offset_o   (offset_o)
  );
endmodule

// File: rtl/ptp_e2e_chk.sv
module ptp_e2e_chk (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               go_i,
  input logic               res_vld_i,
  input logic               res_err_i,
  input logic signed [63:0] delay_i,
  input logic signed [63:0] offset_i
);
  a_r9_pulse_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_vld_i && res_err_i));

  a_r5_due_after_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> ##2 (res_vld_i || res_err_i));

  a_r5_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_i || res_err_i) |-> $past(go_i, 2));

  a_r7_delay_nonneg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_i |-> !delay_i[63]);

  a_r9_hold_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_vld_i |-> ($stable(delay_i) && $stable(offset_i)));

  a_r7_err_no_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_err_i |-> $stable(delay_i));
endmodule

bind ptp_e2e_calc ptp_e2e_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .go_i     (go),
  .res_vld_i(res_vld_o),
  .res_err_i(res_err_o),
  .delay_i  (delay_o),
  .offset_i (offset_o)
);

// File: tb/ptp_e2e_calc_tb.sv
module ptp_e2e_calc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  vld = '0;
  logic [47:0] t_sec [4];
  logic [31:0] t_ns  [4];
  logic signed [63:0] corr_s = '0, corr_d = '0;
  logic signed [31:0] asym = '0;
  logic [31:0] tx_lat = '0, rx_lat = '0;
  logic        res_vld, res_err;
  logic signed [63:0] delay, offset;
  int checks = 0, errs = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ptp_e2e_calc u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .t1_vld_i(vld[0]), .t1_sec_i(t_sec[0]), .t1_ns_i(t_ns[0]),
    .t2_vld_i(vld[1]), .t2_sec_i(t_sec[1]), .t2_ns_i(t_ns[1]),
    .t3_vld_i(vld[2]), .t3_sec_i(t_sec[2]), .t3_ns_i(t_ns[2]),
    .t4_vld_i(vld[3]), .t4_sec_i(t_sec[3]), .t4_ns_i(t_ns[3]),
    .corr_sync_i(corr_s), .corr_dreq_i(corr_d), .asym_i(asym),
    .tx_lat_i(tx_lat), .rx_lat_i(rx_lat),
    .res_vld_o(res_vld), .res_err_o(res_err), .delay_o(delay), .offset_o(offset)
  );

  typedef struct packed {
    logic [47:0] s1; logic [31:0] n1;
    logic [47:0] s2; logic [31:0] n2;
    logic [47:0] s3; logic [31:0] n3;
    logic [47:0] s4; logic [31:0] n4;
    longint cs; longint cd; int asy;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{48'd10, 32'd0, 48'd10, 32'd1500, 48'd10, 32'd5000, 48'd10, 32'd6000, 64'sd0, 64'sd0, 32'sd0},
    '{48'd5, 32'd999999900, 48'd6, 32'd100, 48'd6, 32'd1000, 48'd6, 32'd1150, 64'sd20, 64'sd10, 32'sd5},
    '{48'd1, 32'd0, 48'd0, 32'd999999000, 48'd1, 32'd0, 48'd1, 32'd3001, 64'sd0, 64'sd0, 32'sd0},
    '{48'd100, 32'd500, 48'd100, 32'd900, 48'd100, 32'd2000, 48'd100, 32'd2300, 64'sd0, 64'sd0, -32'sd30}
  };

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic longint nrm(int i, bit tx);
    longint v = longint'(t_sec[i]) * 1000000000 + longint'(t_ns[i]);
    return tx ? v + longint'(tx_lat) : v - longint'(rx_lat);
  endfunction

  function automatic longint half_floor(longint s);
    return (s >= 0) ? s / 2 : -((-s + 1) / 2);
  endfunction

  // expected results from the current bench inputs, given captured corrections
  task automatic model(longint cs, longint cd, output longint d, output longint o);
    longint f, r;
    f = nrm(1, 0) - nrm(0, 1) - cs;
    r = nrm(3, 0) - nrm(2, 1) - cd;
    d = half_floor(f + r);
    o = f - d - longint'(asym);
  endtask

  task automatic strobe(logic [3:0] m);
    @(negedge clk); vld = m;
    @(negedge clk); vld = '0;
  endtask

  task automatic expect_res(longint d, longint o, string req);
    @(negedge clk); chk(!res_vld, "R5 early", res_vld, 0);
    @(negedge clk);
    chk(res_vld && !res_err, {req, " valid"}, res_vld, 1);
    chk(delay == d, {req, " delay"}, delay, d);
    chk(offset == o, {req, " offset"}, offset, o);
    @(negedge clk); chk(!res_vld, "R9 pulse", res_vld, 0);
  endtask

  task automatic set_ts(int i, logic [47:0] s, logic [31:0] n);
    t_sec[i] = s; t_ns[i] = n;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL R5 watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    longint ed, eo, pd, po;
    for (int i = 0; i < 4; i++) set_ts(i, '0, '0);
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(!res_vld && !res_err, "R8 reset pulses", res_vld, 0);
    chk(delay == 0 && offset == 0, "R8 reset values", delay, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table: all four strobes in one cycle (R3 R4 R5)
    for (int k = 0; k < 4; k++) begin
      set_ts(0, VEC[k].s1, VEC[k].n1); set_ts(1, VEC[k].s2, VEC[k].n2);
      set_ts(2, VEC[k].s3, VEC[k].n3); set_ts(3, VEC[k].s4, VEC[k].n4);
      corr_s = VEC[k].cs; corr_d = VEC[k].cd; asym = VEC[k].asy;
      model(VEC[k].cs, VEC[k].cd, ed, eo);
      strobe(4'b1111);
      expect_res(ed, eo, "R3 R4 table");
    end

    // R5 out of order, spread over cycles
    corr_s = 0; corr_d = 0; asym = 0;
    set_ts(0, 48'd50, 32'd0); set_ts(1, 48'd50, 32'd800);
    set_ts(2, 48'd50, 32'd3000); set_ts(3, 48'd50, 32'd3600);
    strobe(4'b1000); strobe(4'b0001); @(negedge clk); strobe(4'b0100);
    chk(!res_vld, "R5 incomplete", res_vld, 0);
    strobe(4'b0010);
    expect_res(700, 100, "R5 order");

    // R6 repeated strobe replaces value
    set_ts(0, 48'd50, 32'd400); strobe(4'b0001);
    set_ts(0, 48'd50, 32'd0);   strobe(4'b0001);
    strobe(4'b1110);
    expect_res(700, 100, "R6 overwrite");

    // R1 latencies
    tx_lat = 32'd7; rx_lat = 32'd3;
    model(0, 0, ed, eo);
    chk(ed == 690, "R1 model", ed, 690);
    strobe(4'b1111);
    expect_res(ed, eo, "R1 latency");
    tx_lat = 0; rx_lat = 0;

    // R2 correction sampled only with t2/t4 strobes
    corr_s = 64'sd40; strobe(4'b0011);
    corr_s = 64'sd9999; corr_d = 64'sd20; strobe(4'b0100);
    corr_d = 64'sd5; strobe(4'b1000);
    corr_d = 64'sd7777;
    model(40, 5, ed, eo);
    expect_res(ed, eo, "R2 corr capture");
    pd = ed; po = eo;
    corr_s = 0; corr_d = 0;

    // R7 negative mean delay
    set_ts(0, 48'd20, 32'd10000); set_ts(1, 48'd20, 32'd5000);
    set_ts(2, 48'd20, 32'd0);     set_ts(3, 48'd20, 32'd100);
    strobe(4'b1111);
    @(negedge clk);
    @(negedge clk);
    chk(res_err && !res_vld, "R7 err pulse", res_err, 1);
    chk(delay == pd && offset == po, "R7 hold", delay, pd);
    @(negedge clk); chk(!res_err, "R9 err pulse", res_err, 0);

    // R8 reset discards pending timestamps
    set_ts(0, 48'd50, 32'd0); set_ts(1, 48'd50, 32'd800);
    set_ts(2, 48'd50, 32'd3000); set_ts(3, 48'd50, 32'd3600);
    strobe(4'b0011);
    rst_n = 1'b0; @(negedge clk);
    chk(delay == 0 && offset == 0, "R8 reset clears", delay, 0);
    rst_n = 1'b1; @(negedge clk);
    strobe(4'b1100);
    begin
      bit seen = 0;
      for (int c = 0; c < 5; c++) begin
        @(negedge clk);
        if (res_vld || res_err) seen = 1;
      end
      chk(!seen, "R8 pending dropped", seen, 0);
    end
    strobe(4'b0011);
    expect_res(700, 100, "R8 after reset");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule